// File: doc/BRIEF.md
# Filtered CAN Receive FIFO

This block sits between a CAN protocol engine and the host. Every frame the engine delivers (identifier, extended-format bit, length code and eight data bytes) is checked against a small table of acceptance rows that the host programs. A frame that satisfies at least one enabled row is written into a six-entry queue together with the index of the lowest row it satisfied. A frame that satisfies no row is dropped without a trace. The host takes frames out oldest first through a read port whose head entry is always visible.

The queue never stalls the engine. When it is full and another accepted frame arrives with no read in the same cycle, the oldest stored frame is overwritten and a sticky overflow flag is raised. A sticky watermark flag tells the host that the occupancy has reached a programmable threshold. Both flags are cleared by a one-cycle write-one pulse on their clear inputs.

Each row has one of four kinds. A mask row compares only the identifier bits selected by a mask. A single row matches one identifier. A dual row matches either of two identifiers. A range row matches an inclusive span. Each row also names the identifier format it applies to, so one table can filter 11-bit standard and 29-bit extended identifiers.

Top module: `can_rx_filter_fifo`

## Requirements
- R1: After reset the queue is empty, `rdValid` and `fillLevel` are 0, both flags are 0, and every filter row is disabled.
- R2: The row kind codes are 0 = mask (match when `((id ^ idA) & idB) == 0`), 1 = single (`id == idA`), 2 = dual (`id == idA` or `id == idB`) and 3 = range (`idA <= id <= idB`). A row matches only frames whose `frmExt` equals the row's `fltWrExt`. A standard frame is compared on `frmId[10:0]` with the upper bits taken as zero, and a standard row's `idA` and `idB` are stored with their upper 18 bits cleared.
- R3: A valid frame that matches no enabled row leaves `fillLevel` and the queue contents unchanged.
- R4: When several rows match, `rdRow` returns the lowest matching row index for that frame.
- R5: Accepted frames are read back in arrival order. The `rdId`, `rdExt`, `rdDlc` and `rdData` outputs show the head entry exactly as it was received, and `fillLevel` gives the number of stored frames.
- R6: `wmFlag` goes to 1 on the clock edge where the occupancy becomes greater than or equal to `wmThresh`. It stays at 1 after the occupancy drops, until a `wmClr` pulse clears it. If the occupancy is still at or above the threshold, the clear does not take effect.
- R7: An accepted frame that arrives while the queue holds 6 entries, with no pop in the same cycle, overwrites the oldest entry. `fillLevel` stays at 6 and `ovfFlag` goes to 1. `ovfFlag` stays at 1 until an `ovfClr` pulse.
- R8: When an accepted frame and a pop fall in the same cycle while the queue is full, the pop removes the head, the new frame is stored, `fillLevel` stays at 6 and `ovfFlag` does not change.
- R9: A pop while the queue is empty has no effect: `fillLevel` stays at 0, and a frame stored afterwards reads back correctly.
- R10: A row that has been written with `fltWrValid` = 0, or has never been written, matches no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fltWrEn | input | 1 | Write strobe for one filter row |
| fltWrRow | input | 2 | Index of the row being written |
| fltWrValid | input | 1 | Enables the row being written |
| fltWrType | input | 2 | Row kind: 0 mask, 1 single, 2 dual, 3 range |
| fltWrExt | input | 1 | Identifier format the row applies to (1 = 29-bit) |
| fltWrIdA | input | 29 | First identifier, range low bound, or mask compare value |
| fltWrIdB | input | 29 | Second identifier, range high bound, or mask |
| frmValid | input | 1 | A received frame is present this cycle |
| frmId | input | 29 | Identifier of the received frame |
| frmExt | input | 1 | Frame uses a 29-bit identifier |
| frmDlc | input | 4 | Data length code of the frame |
| frmData | input | 64 | Payload bytes of the frame |
| rdPop | input | 1 | Removes the head entry |
| rdValid | output | 1 | Queue holds at least one frame |
| rdId | output | 29 | Identifier of the head entry |
| rdExt | output | 1 | Format bit of the head entry |
| rdDlc | output | 4 | Length code of the head entry |
| rdData | output | 64 | Payload of the head entry |
| rdRow | output | 2 | Lowest filter row that accepted the head entry |
| fillLevel | output | 3 | Number of stored frames |
| wmThresh | input | 3 | Watermark occupancy threshold |
| wmFlag | output | 1 | Sticky watermark flag |
| wmClr | input | 1 | Write-one clear of `wmFlag` |
| ovfFlag | output | 1 | Sticky overflow flag |
| ovfClr | input | 1 | Write-one clear of `ovfFlag` |

## Verification
An accepted frame and a host pop can fall in the same clock cycle. When the queue is full this pairing decides between a plain exchange and an overwrite. The bench first fills the queue to six and sends a seventh accepted frame with no pop. It expects the scoreboard to lose its oldest entry and the overflow flag to rise. After clearing the flag, it pulses `rdPop` in the same cycle as an eighth accepted frame. It then expects the level to stay at six, the flag to stay clear, and the six remaining frames to drain in the order the reference queue predicts.

// File: rtl/rxff_pkg.sv
package rxff_pkg;
  localparam int ID_W   = 29;
  localparam int STD_W  = 11;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;

  typedef enum logic [1:0] {
    FLT_MASK   = 2'd0,
    FLT_SINGLE = 2'd1,
    FLT_DUAL   = 2'd2,
    FLT_RANGE  = 2'd3
  } fltKind_e;

  typedef struct packed {
    logic             valid;
    fltKind_e         kind;
    logic             ext;
    logic [ID_W-1:0]  idA;
    logic [ID_W-1:0]  idB;
  } fltRow_t;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              ext;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } rxFrame_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;       // store incoming frame at write pointer
    logic pop;        // host removes head
    logic overwrite;  // full and pushing without pop: drop oldest
  } fifoStb_t;

  function automatic logic [ID_W-1:0] normId(input logic [ID_W-1:0] id, input logic ext);
    return ext ? id : {{(ID_W-STD_W){1'b0}}, id[STD_W-1:0]};
  endfunction
endpackage

// File: rtl/rxff_datapath.sv
module rxff_datapath
  import rxff_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int ROWS  = 4,
  parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int RIW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fltWrEn,
  input  logic [RIW-1:0]    fltWrRow,
  input  logic              fltWrValid,
  input  logic [1:0]        fltWrType,
  input  logic              fltWrExt,
  input  logic [ID_W-1:0]   fltWrIdA,
  input  logic [ID_W-1:0]   fltWrIdB,
  input  rxFrame_t          frmIn,
  input  fifoStb_t          stb,
  output logic              matchHit,
  output rxFrame_t          headFrame,
  output logic [RIW-1:0]    headRow
);
  fltRow_t          rows [ROWS];
  logic [ROWS-1:0]  hitVec;
  logic [RIW-1:0]   matchIdx;
  logic [ID_W-1:0]  key;

  rxFrame_t         frameMem [DEPTH];
  logic [RIW-1:0]   rowMem   [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // filter table storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) rows[r] <= '0;
    end else if (fltWrEn && (int'(fltWrRow) < ROWS)) begin
      rows[fltWrRow].valid <= fltWrValid;
      rows[fltWrRow].kind  <= fltKind_e'(fltWrType);
      rows[fltWrRow].ext   <= fltWrExt;
      rows[fltWrRow].idA   <= normId(fltWrIdA, fltWrExt);
      rows[fltWrRow].idB   <= normId(fltWrIdB, fltWrExt);
    end
  end

  assign key = normId(frmIn.id, frmIn.ext);

  // per-row comparators
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic kindHit;
    always_comb begin
      unique case (rows[r].kind)
        FLT_MASK:   kindHit = ((key ^ rows[r].idA) & rows[r].idB) == '0;
        FLT_SINGLE: kindHit = (key == rows[r].idA);
        FLT_DUAL:   kindHit = (key == rows[r].idA) || (key == rows[r].idB);
        FLT_RANGE:  kindHit = (key >= rows[r].idA) && (key <= rows[r].idB);
        default:    kindHit = 1'b0;
      endcase
    end
    assign hitVec[r] = rows[r].valid && (rows[r].ext == frmIn.ext) && kindHit;
  end

  // lowest index wins
  always_comb begin
    matchIdx = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (hitVec[r]) matchIdx = RIW'(r);
    end
  end
  assign matchHit = |hitVec;

  // queue storage and pointers
  always_ff @(posedge clk) begin
    if (stb.push) begin
      frameMem[wrPtr] <= frmIn;
      rowMem[wrPtr]   <= matchIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.push) wrPtr <= bump(wrPtr);
      if (stb.pop || stb.overwrite) rdPtr <= bump(rdPtr);
    end
  end

  assign headFrame = frameMem[rdPtr];
  assign headRow   = rowMem[rdPtr];

  AST_LOWEST_ROW: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |-> (hitVec[matchIdx] && ((hitVec & ~({ROWS{1'b1}} << matchIdx)) == '0))); // R4
  AST_OVERWRITE_PTRS: assert property (@(posedge clk) disable iff (!rstN)
    stb.overwrite |-> (wrPtr == rdPtr)); // R7
endmodule

// File: rtl/rxff_ctrl.sv
module rxff_ctrl
  import rxff_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frmValid,
  input  logic          matchHit,
  input  logic          rdPop,
  input  logic [CW-1:0] wmThresh,
  input  logic          wmClr,
  input  logic          ovfClr,
  output fifoStb_t      stb,
  output logic [CW-1:0] count,
  output logic          wmFlag,
  output logic          ovfFlag
);
  logic          accept, full, empty, popOk, ovfEvent;
  logic [CW-1:0] countNext;

  assign accept   = frmValid && matchHit;
  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign popOk    = rdPop && !empty;
  assign ovfEvent = accept && full && !popOk;

  assign stb.push      = accept;
  assign stb.pop       = popOk;
  assign stb.overwrite = ovfEvent;

  always_comb begin
    countNext = count;
    if (accept && !popOk && !full) countNext = count + 1'b1;
    else if (popOk && !accept)     countNext = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      wmFlag  <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      count   <= countNext;
      wmFlag  <= (wmFlag && !wmClr) || (countNext >= wmThresh);
      ovfFlag <= (ovfFlag && !ovfClr) || ovfEvent;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R7
  AST_OVF_STAYS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (accept && full && !popOk) |=> (count == CW'(DEPTH) && ovfFlag)); // R7
  AST_SWAP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (accept && full && popOk) |=> (count == CW'(DEPTH) && ovfFlag == $past(ovfFlag && !ovfClr))); // R8
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    (empty && rdPop && !accept) |=> (count == '0)); // R9
  AST_DROP_NOMATCH: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && !matchHit && !rdPop) |=> (count == $past(count))); // R3
endmodule

// File: rtl/can_rx_filter_fifo.sv
module can_rx_filter_fifo
  import rxff_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int ROWS  = 4,
  parameter int RIW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fltWrEn,
  input  logic [RIW-1:0]    fltWrRow,
  input  logic              fltWrValid,
  input  logic [1:0]        fltWrType,
  input  logic              fltWrExt,
  input  logic [ID_W-1:0]   fltWrIdA,
  input  logic [ID_W-1:0]   fltWrIdB,
  input  logic              frmValid,
  input  logic [ID_W-1:0]   frmId,
  input  logic              frmExt,
  input  logic [DLC_W-1:0]  frmDlc,
  input  logic [DATA_W-1:0] frmData,
  input  logic              rdPop,
  output logic              rdValid,
  output logic [ID_W-1:0]   rdId,
  output logic              rdExt,
  output logic [DLC_W-1:0]  rdDlc,
  output logic [DATA_W-1:0] rdData,
  output logic [RIW-1:0]    rdRow,
  output logic [CW-1:0]     fillLevel,
  input  logic [CW-1:0]     wmThresh,
  output logic              wmFlag,
  input  logic              wmClr,
  output logic              ovfFlag,
  input  logic              ovfClr
);
  fifoStb_t stb;
  logic     matchHit;
  rxFrame_t frmIn, headFrame;

  assign frmIn = '{id: frmId, ext: frmExt, dlc: frmDlc, data: frmData};

  rxff_ctrl #(.DEPTH(DEPTH), .CW(CW)) ctrl_i (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .matchHit(matchHit),
    .rdPop(rdPop), .wmThresh(wmThresh), .wmClr(wmClr), .ovfClr(ovfClr),
    .stb(stb), .count(fillLevel), .wmFlag(wmFlag), .ovfFlag(ovfFlag)
  );

  rxff_datapath #(.DEPTH(DEPTH), .ROWS(ROWS), .RIW(RIW)) dp_i (
    .clk(clk), .rstN(rstN), .fltWrEn(fltWrEn), .fltWrRow(fltWrRow),
    .fltWrValid(fltWrValid), .fltWrType(fltWrType), .fltWrExt(fltWrExt),
    .fltWrIdA(fltWrIdA), .fltWrIdB(fltWrIdB), .frmIn(frmIn), .stb(stb),
    .matchHit(matchHit), .headFrame(headFrame), .headRow(rdRow)
  );

  assign rdValid = (fillLevel != '0);
  assign rdId    = headFrame.id;
  assign rdExt   = headFrame.ext;
  assign rdDlc   = headFrame.dlc;
  assign rdData  = headFrame.data;
endmodule

// File: tb/can_rx_filter_fifo_tb_top.sv
module can_rx_filter_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fltWrEn = 0, fltWrValid = 0, fltWrExt = 0;
  logic [1:0]  fltWrRow = 0, fltWrType = 0;
  logic [28:0] fltWrIdA = 0, fltWrIdB = 0;
  logic        frmValid = 0, frmExt = 0, rdPop = 0, wmClr = 0, ovfClr = 0;
  logic [28:0] frmId = 0;
  logic [3:0]  frmDlc = 0;
  logic [63:0] frmData = 0;
  logic [2:0]  wmThresh = 3'd4;
  logic        rdValid, rdExt, wmFlag, ovfFlag;
  logic [28:0] rdId;
  logic [3:0]  rdDlc;
  logic [63:0] rdData;
  logic [1:0]  rdRow;
  logic [2:0]  fillLevel;

  always #4 clk = ~clk; // 125 MHz

  can_rx_filter_fifo dut_i (
    .clk(clk), .rstN(rstN), .fltWrEn(fltWrEn), .fltWrRow(fltWrRow),
    .fltWrValid(fltWrValid), .fltWrType(fltWrType), .fltWrExt(fltWrExt),
    .fltWrIdA(fltWrIdA), .fltWrIdB(fltWrIdB), .frmValid(frmValid),
    .frmId(frmId), .frmExt(frmExt), .frmDlc(frmDlc), .frmData(frmData),
    .rdPop(rdPop), .rdValid(rdValid), .rdId(rdId), .rdExt(rdExt),
    .rdDlc(rdDlc), .rdData(rdData), .rdRow(rdRow), .fillLevel(fillLevel),
    .wmThresh(wmThresh), .wmFlag(wmFlag), .wmClr(wmClr),
    .ovfFlag(ovfFlag), .ovfClr(ovfClr)
  );

  typedef struct packed {
    logic [28:0] id;
    logic        ext;
    logic [3:0]  dlc;
    logic [63:0] data;
    logic [1:0]  row;
  } expItem_t;

  expItem_t    sbQ[$];
  int          checks = 0, failures = 0;
  bit          done = 0;
  bit          mValid[4];
  logic [1:0]  mKind[4];
  bit          mExt[4];
  logic [28:0] mA[4], mB[4];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int refRow(input logic [28:0] id, input bit ext);
    logic [28:0] k = ext ? id : {18'd0, id[10:0]};
    for (int r = 0; r < 4; r++) begin
      if (mValid[r] && mExt[r] == ext) begin
        case (mKind[r])
          2'd0: if (((k ^ mA[r]) & mB[r]) == 0) return r;
          2'd1: if (k == mA[r]) return r;
          2'd2: if (k == mA[r] || k == mB[r]) return r;
          default: if (k >= mA[r] && k <= mB[r]) return r;
        endcase
      end
    end
    return -1;
  endfunction

  task automatic writeRow(input int r, input bit v, input logic [1:0] kind,
                          input bit ext, input logic [28:0] a, input logic [28:0] b);
    @(negedge clk);
    fltWrEn = 1; fltWrRow = 2'(r); fltWrValid = v; fltWrType = kind;
    fltWrExt = ext; fltWrIdA = a; fltWrIdB = b;
    mValid[r] = v; mKind[r] = kind; mExt[r] = ext; mA[r] = a; mB[r] = b;
    @(negedge clk);
    fltWrEn = 0;
  endtask

  // head of monitor: compare before a pop
  task automatic cmpHead(input string req);
    expItem_t e = sbQ[0];
    chk(rdValid == 1'b1, req, "rdValid", 64'(rdValid), 64'd1);
    chk(rdId == e.id, req, "rdId", 64'(rdId), 64'(e.id));
    chk(rdExt == e.ext, req, "rdExt", 64'(rdExt), 64'(e.ext));
    chk(rdDlc == e.dlc, req, "rdDlc", 64'(rdDlc), 64'(e.dlc));
    chk(rdData == e.data, req, "rdData", rdData, e.data);
    chk(rdRow == e.row, "R4", "rdRow", 64'(rdRow), 64'(e.row));
  endtask

  // driver: present one frame, optionally with a pop in the same cycle
  task automatic sendFrame(input logic [28:0] id, input bit ext, input bit withPop,
                           input string req);
    int r = refRow(id, ext);
    @(negedge clk);
    if (withPop) begin
      cmpHead("R8");
      void'(sbQ.pop_front());
      rdPop = 1;
    end
    frmValid = 1; frmId = id; frmExt = ext; frmDlc = 4'(id[3:0] % 9);
    frmData = {id[15:0], ~id[15:0], id[15:0] ^ 16'h5A5A, 15'(id[28:16]), ext};
    if (r >= 0) begin
      if (sbQ.size() == 6) void'(sbQ.pop_front());
      sbQ.push_back('{id: id, ext: ext, dlc: frmDlc, data: frmData, row: 2'(r)});
    end
    @(negedge clk);
    frmValid = 0; rdPop = 0;
    chk(fillLevel == 3'(sbQ.size()), req, "fillLevel", 64'(fillLevel), 64'(sbQ.size()));
  endtask

  // monitor: pop head and compare against scoreboard
  task automatic popCheck(input string req);
    @(negedge clk);
    cmpHead(req);
    void'(sbQ.pop_front());
    rdPop = 1;
    @(negedge clk);
    rdPop = 0;
    chk(fillLevel == 3'(sbQ.size()), req, "fillLevel after pop", 64'(fillLevel), 64'(sbQ.size()));
  endtask

  task automatic pulseClr(input bit w, input bit o);
    @(negedge clk);
    wmClr = w; ovfClr = o;
    @(negedge clk);
    wmClr = 0; ovfClr = 0;
  endtask

  initial begin
    for (int r = 0; r < 4; r++) begin
      mValid[r] = 0; mKind[r] = 0; mExt[r] = 0; mA[r] = 0; mB[r] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(rdValid == 0, "R1", "rdValid", 64'(rdValid), 0);
    chk(fillLevel == 0, "R1", "fillLevel", 64'(fillLevel), 0);
    chk(wmFlag == 0, "R1", "wmFlag", 64'(wmFlag), 0);
    chk(ovfFlag == 0, "R1", "ovfFlag", 64'(ovfFlag), 0);

    // no row enabled yet: frames are dropped (R10, R1)
    sendFrame(29'h123, 0, 0, "R10");
    // row written disabled still drops
    writeRow(0, 0, 2'd1, 0, 29'h123, 0);
    sendFrame(29'h123, 0, 0, "R10");

    // program table
    writeRow(0, 1, 2'd1, 0, 29'h123, 29'h0);            // single std
    writeRow(1, 1, 2'd2, 1, 29'h1ABCDE01, 29'h42);      // dual ext
    writeRow(2, 1, 2'd3, 0, 29'h100, 29'h1FF);          // range std
    writeRow(3, 1, 2'd0, 0, 29'h400, 29'h700);          // mask std

    sendFrame(29'h123, 0, 0, "R4");        // rows 0 and 2 match, expect 0
    sendFrame(29'h150, 0, 0, "R2");        // range
    sendFrame(29'h1ABCDE01, 1, 0, "R2");   // dual first
    sendFrame(29'h042, 0, 0, "R3");        // std format, no row
    sendFrame(29'h042, 1, 0, "R2");        // dual second
    sendFrame(29'h5A7, 0, 0, "R3");        // mask miss
    sendFrame(29'h123, 1, 0, "R3");        // format mismatch
    sendFrame(29'h1FFFF4A7, 0, 0, "R2");   // std uses low 11 bits: 0x4A7 mask hit
    chk(wmFlag == 1, "R6", "wmFlag at level 5", 64'(wmFlag), 1);
    while (sbQ.size() > 0) popCheck("R5");
    chk(wmFlag == 1, "R6", "wmFlag sticky", 64'(wmFlag), 1);
    pulseClr(1, 0);
    chk(wmFlag == 0, "R6", "wmFlag cleared", 64'(wmFlag), 0);

    // overflow
    for (int k = 0; k < 6; k++) sendFrame(29'(12'h100 + k * 7), 0, 0, "R7");
    chk(ovfFlag == 0, "R7", "ovfFlag at full", 64'(ovfFlag), 0);
    sendFrame(29'h1E0, 0, 0, "R7");
    chk(ovfFlag == 1, "R7", "ovfFlag after overwrite", 64'(ovfFlag), 1);
    chk(fillLevel == 6, "R7", "fillLevel stays full", 64'(fillLevel), 6);
    pulseClr(0, 1);
    chk(ovfFlag == 0, "R7", "ovfFlag cleared", 64'(ovfFlag), 0);

    // push and pop in one cycle while full
    sendFrame(29'h1F0, 0, 1, "R8");
    chk(ovfFlag == 0, "R8", "ovfFlag unchanged", 64'(ovfFlag), 0);
    while (sbQ.size() > 0) popCheck("R7");

    // pop on empty
    @(negedge clk);
    rdPop = 1;
    @(negedge clk);
    rdPop = 0;
    chk(fillLevel == 0, "R9", "fillLevel after empty pop", 64'(fillLevel), 0);
    chk(rdValid == 0, "R9", "rdValid after empty pop", 64'(rdValid), 0);
    sendFrame(29'h150, 0, 0, "R9");
    popCheck("R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule